// File: doc/BRIEF.md
# Memory Write Undo-Logging Controller

This block sits next to the home memory controller of a directory-based shared-memory node and keeps the memory image of a recent checkpoint recoverable. It holds a small line-granular memory model and one "saved" flag per line, standing in for one extra bit per directory entry. When a line is written for the first time since the last checkpoint, the block first copies the line's address and old contents into an undo log. Only in the following cycle does the new data reach memory. Later writes to the same line in the same interval go straight to memory and leave the log alone.

A checkpoint pulse clears every saved flag and retires the log entries of the older of the two checkpoints held. The entries written since the previous checkpoint stay in the log. A rollback pulse replays the log from the newest entry to the oldest, writing each saved line back. Memory then holds the older retained checkpoint image. The block then clears all flags and empties the log. When the log is full, first-time writes are stalled until a checkpoint frees space. Writes to lines already saved keep flowing while the log is full.

Top module: `undo_log_ctrl`

## Requirements
- R1: After reset every memory line reads zero, no line is marked saved, the log count is zero, `busy` and `rb_done` are low, and `wr_ready` is high.
- R2: A write accepted to a line whose saved flag is clear appends one log entry holding that line's address and old data. On the accepting edge it sets the line's saved flag and raises `log_count` by one.
- R3: For such a first-time write, memory is updated one edge after the log append. `busy` is high and `wr_ready` is low for that one cycle. A write to a line already saved updates memory on its accepting edge and makes no log entry.
- R4: While `log_count` equals LOG_DEPTH, a write to an unsaved line is stalled with `wr_ready` low and leaves memory unchanged. A write to a saved line is still accepted.
- R5: A checkpoint pulse clears all saved flags and frees only the entries logged before the previous checkpoint. Entries logged since the previous checkpoint are kept, so space is freed by the second pulse.
- R6: A rollback pulse replays the log newest-first. Memory ends as it was at the older retained checkpoint, or as at reset if fewer than two checkpoints have been taken. All saved flags are then clear and the log is empty. With N entries, `busy` stays high for N+1 cycles and `rb_done` is high for the single cycle after that.
- R7: When a rollback and a checkpoint pulse arrive together, the rollback wins. In any cycle with either pulse present, `wr_ready` is low.
- R8: Checkpoint and rollback pulses that arrive while `busy` is high are ignored. No write is accepted while `busy` is high.
- R9: `rd_data` and `rd_logged` show the current contents and saved flag of the line at `rd_addr` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request from the coherence side |
| wr_addr | input | ADDR_W | Line address of the write |
| wr_data | input | DATA_W | New line data |
| wr_ready | output | 1 | Write accepted on this edge when high together with wr_valid |
| ckpt_commit | input | 1 | One-cycle checkpoint commit pulse |
| rollback_req | input | 1 | One-cycle rollback request pulse |
| busy | output | 1 | Pending data write or rollback replay in progress |
| rb_done | output | 1 | One-cycle pulse after a rollback completes |
| rd_addr | input | ADDR_W | Line address for the read port |
| rd_data | output | DATA_W | Current contents of line rd_addr |
| rd_logged | output | 1 | Saved flag of line rd_addr |
| log_count | output | $clog2(LOG_DEPTH)+1 | Number of live log entries |

## Verification
The bench drives inputs on the falling edge and samples on the next falling edge. A result due on the accepting rising edge is therefore read half a cycle after it. Log count and saved flag change on the accepting edge. The memory line of a first-time write is read once before and once after the following edge, which shows it lands exactly one cycle late. A write to an already saved line is visible at the first sample. For rollback, the bench counts the falling edges at which `busy` is high and expects N+1 of them. It expects `rb_done` at the first sample with `busy` low and gone at the next one.

// File: rtl/ulog_pkg.sv
// Package: shared types of the undo-logging controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package ulog_pkg;

    // Control states of the sequencer
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // accepting writes and pulses
        ST_DATA   = 2'd1,   // old data logged, new data due this cycle
        ST_REPLAY = 2'd2    // walking the log newest-first
    } ulog_state_e;

endpackage

// File: rtl/ulog_dir.sv
// Module: per-line saved flags, the extra directory bit of each line.
// A flag is set when its line is first logged and all flags clear together.
// Assumes set and clear-all are never requested in the same cycle; clear wins.
module ulog_dir #(
    parameter int ADDR_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_en,
    input  logic [ADDR_W-1:0]     set_idx,
    input  logic                  clr_all,
    output logic [(1<<ADDR_W)-1:0] flags
);
    localparam int LINES = 1 << ADDR_W;

    logic [LINES-1:0] set_dec;

    // One-hot decode of the line being marked
    for (genvar i = 0; i < LINES; i++) begin : g_dec
        assign set_dec[i] = set_en && (set_idx == ADDR_W'(i));
    end

    // Flag register: reset, bulk clear, or set of one line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (clr_all) begin
            flags <= '0;
        end else begin
            flags <= flags | set_dec;
        end
    end

endmodule

// File: rtl/ulog_mem.sv
// Module: modelled line memory with one write port and two read ports.
// Read port A feeds the logging path, read port B the external read port.
// Assumes lines reset to zero; reads are combinational.
module ulog_mem #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_data
);
    localparam int LINES = 1 << ADDR_W;

    logic [DATA_W-1:0] line_q [LINES];
    logic [LINES-1:0]  wsel;

    // Decode of the written line
    for (genvar i = 0; i < LINES; i++) begin : g_wsel
        assign wsel[i] = we && (waddr == ADDR_W'(i));
    end

    // Line storage update
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (!rst_n) begin
                line_q[i] <= '0;
            end else if (wsel[i]) begin
                line_q[i] <= wdata;
            end
        end
    end

    // Combinational read ports
    assign ra_data = line_q[ra_addr];
    assign rb_data = line_q[rb_addr];

endmodule

// File: rtl/ulog_buf.sv
// Module: undo log buffer with base, mark and tail pointers.
// base..mark holds entries of the older retained interval, mark..tail the
// current one. Commit retires base..mark; pop walks tail back; flush parks
// mark on base once replay has emptied the log.
// Assumes LOG_DEPTH is a power of two >= 2 and that push, pop and commit
// are mutually exclusive (the sequencer guarantees it).
module ulog_buf #(
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 8,
    parameter int LOG_DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [ADDR_W-1:0]             push_addr,
    input  logic [DATA_W-1:0]             push_data,
    input  logic                          pop,
    input  logic                          commit,
    input  logic                          flush,
    output logic [$clog2(LOG_DEPTH):0]    count,
    output logic                          full,
    output logic                          empty,
    output logic [ADDR_W-1:0]             top_addr,
    output logic [DATA_W-1:0]             top_data
);
    localparam int IW = $clog2(LOG_DEPTH);
    localparam int PW = IW + 1;

    logic [PW-1:0]     base_q, mark_q, tail_q;
    logic [PW-1:0]     tail_m1;
    logic [ADDR_W-1:0] ent_addr [LOG_DEPTH];
    logic [DATA_W-1:0] ent_data [LOG_DEPTH];

    assign tail_m1 = tail_q - PW'(1);

    // Pointer maintenance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mark_q <= '0;
            tail_q <= '0;
        end else if (push) begin
            tail_q <= tail_q + PW'(1);
        end else if (pop) begin
            tail_q <= tail_m1;
        end else if (commit) begin
            base_q <= mark_q;
            mark_q <= tail_q;
        end else if (flush) begin
            mark_q <= base_q;
            tail_q <= base_q;
        end
    end

    // Entry storage, written at the tail slot
    always_ff @(posedge clk) begin
        if (push) begin
            ent_addr[tail_q[IW-1:0]] <= push_addr;
            ent_data[tail_q[IW-1:0]] <= push_data;
        end
    end

    // Occupancy and newest entry
    assign count    = tail_q - base_q;
    assign full     = (count == PW'(LOG_DEPTH));
    assign empty    = (count == '0);
    assign top_addr = ent_addr[tail_m1[IW-1:0]];
    assign top_data = ent_data[tail_m1[IW-1:0]];

endmodule

// File: rtl/ulog_ctrl.sv
// Module: sequencer for writes, checkpoint commit and rollback replay.
// A first-time write logs the old line on its accepting edge and writes
// memory on the next; a repeat write goes straight to memory. Rollback
// pops one entry per cycle into memory, then clears flags and pointers.
// Assumes pulses are one cycle wide; they are honoured only while idle.
module ulog_ctrl
    import ulog_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              commit_req,
    input  logic              rb_req,
    input  logic              line_saved,
    input  logic              log_full,
    input  logic              log_empty,
    input  logic [ADDR_W-1:0] top_addr,
    input  logic [DATA_W-1:0] top_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              log_push,
    output logic              dir_set,
    output logic              dir_clr,
    output logic              buf_pop,
    output logic              buf_commit,
    output logic              buf_flush,
    output logic              rb_active,
    output logic              commit_go,
    output logic              busy,
    output logic              rb_done
);
    ulog_state_e       state_q, state_d;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [DATA_W-1:0] pend_data_q;
    logic              done_q;
    logic              idle, rb_go, accept, hit_w, miss_w, replay_wr, replay_end;

    // Request qualification
    assign idle       = (state_q == ST_IDLE);
    assign rb_go      = idle && rb_req;
    assign commit_go  = idle && commit_req && !rb_req;
    assign wr_ready   = idle && !commit_req && !rb_req && (line_saved || !log_full);
    assign accept     = wr_valid && wr_ready;
    assign hit_w      = accept && line_saved;
    assign miss_w     = accept && !line_saved;
    assign replay_wr  = (state_q == ST_REPLAY) && !log_empty;
    assign replay_end = (state_q == ST_REPLAY) && log_empty;

    // Side-effect strobes to the flag, buffer and memory blocks
    assign log_push   = miss_w;
    assign dir_set    = miss_w;
    assign dir_clr    = commit_go || replay_end;
    assign buf_commit = commit_go;
    assign buf_pop    = replay_wr;
    assign buf_flush  = replay_end;
    assign rb_active  = (state_q == ST_REPLAY);
    assign busy       = !idle;
    assign rb_done    = done_q;

    // Memory write port selection
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = wr_addr;
        mem_wdata = wr_data;
        if (state_q == ST_DATA) begin
            mem_we    = 1'b1;
            mem_waddr = pend_addr_q;
            mem_wdata = pend_data_q;
        end else if (replay_wr) begin
            mem_we    = 1'b1;
            mem_waddr = top_addr;
            mem_wdata = top_data;
        end else if (hit_w) begin
            mem_we    = 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (rb_go)       state_d = ST_REPLAY;
                else if (miss_w) state_d = ST_DATA;
            end
            ST_DATA:   state_d = ST_IDLE;
            ST_REPLAY: if (log_empty) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State, held write and completion pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pend_addr_q <= '0;
            pend_data_q <= '0;
            done_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= replay_end;
            if (miss_w) begin
                pend_addr_q <= wr_addr;
                pend_data_q <= wr_data;
            end
        end
    end

endmodule

// File: rtl/undo_log_ctrl.sv
// Module: top of the undo-logging controller.
// Connects the flag array, line memory, log buffer and sequencer.
// Assumes one write request at a time from the coherence side.
module undo_log_ctrl #(
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 8,
    parameter int LOG_DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    output logic                       wr_ready,
    input  logic                       ckpt_commit,
    input  logic                       rollback_req,
    output logic                       busy,
    output logic                       rb_done,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       rd_logged,
    output logic [$clog2(LOG_DEPTH):0] log_count
);
    localparam int LINES = 1 << ADDR_W;

    logic [LINES-1:0]  saved_vec;
    logic              line_saved, log_full, log_empty;
    logic [ADDR_W-1:0] top_addr, mem_waddr;
    logic [DATA_W-1:0] top_data, mem_wdata, old_data;
    logic              mem_we, log_push, dir_set, dir_clr;
    logic              buf_pop, buf_commit, buf_flush, rb_active, commit_go;

    assign line_saved = saved_vec[wr_addr];
    assign rd_logged  = saved_vec[rd_addr];

    ulog_dir #(.ADDR_W(ADDR_W)) i_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (dir_set),
        .set_idx (wr_addr),
        .clr_all (dir_clr),
        .flags   (saved_vec)
    );

    ulog_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .ra_addr (wr_addr),
        .ra_data (old_data),
        .rb_addr (rd_addr),
        .rb_data (rd_data)
    );

    ulog_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOG_DEPTH(LOG_DEPTH)) i_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (log_push),
        .push_addr (wr_addr),
        .push_data (old_data),
        .pop       (buf_pop),
        .commit    (buf_commit),
        .flush     (buf_flush),
        .count     (log_count),
        .full      (log_full),
        .empty     (log_empty),
        .top_addr  (top_addr),
        .top_data  (top_data)
    );

    ulog_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .commit_req (ckpt_commit),
        .rb_req     (rollback_req),
        .line_saved (line_saved),
        .log_full   (log_full),
        .log_empty  (log_empty),
        .top_addr   (top_addr),
        .top_data   (top_data),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .log_push   (log_push),
        .dir_set    (dir_set),
        .dir_clr    (dir_clr),
        .buf_pop    (buf_pop),
        .buf_commit (buf_commit),
        .buf_flush  (buf_flush),
        .rb_active  (rb_active),
        .commit_go  (commit_go),
        .busy       (busy),
        .rb_done    (rb_done)
    );

endmodule

// File: rtl/ulog_chk.sv
// Module: property checker for the undo-logging controller, bound to the top.
// Assumes the signals it observes are those of undo_log_ctrl.
module ulog_chk #(
    parameter int ADDR_W    = 3,
    parameter int LOG_DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_valid,
    input logic                       wr_ready,
    input logic                       line_saved,
    input logic                       log_full,
    input logic                       log_push,
    input logic [$clog2(LOG_DEPTH):0] log_count,
    input logic                       mem_we,
    input logic [ADDR_W-1:0]          mem_waddr,
    input logic                       rb_active,
    input logic [(1<<ADDR_W)-1:0]     saved_vec,
    input logic                       commit_go,
    input logic                       rb_done,
    input logic                       busy
);
    // R3
    mem_after_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !rb_active) |-> saved_vec[mem_waddr]);

    // R4
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && log_full && !line_saved) |-> !wr_ready);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        log_push |-> !log_full);

    // R4
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        log_count <= ($clog2(LOG_DEPTH)+1)'(LOG_DEPTH));

    // R2
    append_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        log_push |=> (log_count == $past(log_count) + 1'b1));

    // R5
    commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_go |=> (saved_vec == '0));

    // R6
    rb_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_done |-> (log_count == '0 && saved_vec == '0 && !busy));

    // R8
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_ready);

endmodule

bind undo_log_ctrl ulog_chk #(.ADDR_W(ADDR_W), .LOG_DEPTH(LOG_DEPTH)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .line_saved (line_saved),
    .log_full   (log_full),
    .log_push   (log_push),
    .log_count  (log_count),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .rb_active  (rb_active),
    .saved_vec  (saved_vec),
    .commit_go  (commit_go),
    .rb_done    (rb_done),
    .busy       (busy)
);

// File: tb/test_undo_log_ctrl.sv
module test_undo_log_ctrl;
    localparam int AW = 3;
    localparam int DW = 8;
    localparam int LD = 4;
    localparam int CW = $clog2(LD) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ready;
    logic          ckpt_commit = 1'b0;
    logic          rollback_req = 1'b0;
    logic          busy, rb_done;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          rd_logged;
    logic [CW-1:0] log_count;

    int n_chk  = 0;
    int n_fail = 0;

    undo_log_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LOG_DEPTH(LD)) i_undo_log_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ready(wr_ready), .ckpt_commit(ckpt_commit),
        .rollback_req(rollback_req), .busy(busy), .rb_done(rb_done),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_logged(rd_logged),
        .log_count(log_count)
    );

    always #5 clk = ~clk;

    // Vector: op[26:25] (0 write, 1 commit, 2 rollback), addr[24:22],
    // data[21:14], check line[13:11], expected data[10:3], expected count[2:0]
    localparam int NV = 12;
    localparam logic [26:0] VEC [NV] = '{
        {2'd0, 3'd1, 8'h11, 3'd1, 8'h11, 3'd1},
        {2'd0, 3'd1, 8'h22, 3'd1, 8'h22, 3'd1},
        {2'd0, 3'd2, 8'h33, 3'd2, 8'h33, 3'd2},
        {2'd1, 3'd0, 8'h00, 3'd1, 8'h22, 3'd2},
        {2'd0, 3'd1, 8'h44, 3'd1, 8'h44, 3'd3},
        {2'd0, 3'd3, 8'h55, 3'd3, 8'h55, 3'd4},
        {2'd2, 3'd0, 8'h00, 3'd1, 8'h00, 3'd0},
        {2'd0, 3'd4, 8'h66, 3'd4, 8'h66, 3'd1},
        {2'd1, 3'd0, 8'h00, 3'd4, 8'h66, 3'd1},
        {2'd0, 3'd4, 8'h77, 3'd4, 8'h77, 3'd2},
        {2'd1, 3'd0, 8'h00, 3'd4, 8'h77, 3'd1},
        {2'd2, 3'd0, 8'h00, 3'd4, 8'h66, 3'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 50 && busy; k++) @(negedge clk);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        for (int k = 0; k < 50 && !wr_ready; k++) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        wait_idle();
    endtask

    task automatic pulse(input bit rb);
        @(negedge clk);
        if (rb) rollback_req = 1'b1; else ckpt_commit = 1'b1;
        @(negedge clk);
        rollback_req = 1'b0; ckpt_commit = 1'b0;
        wait_idle();
    endtask

    task automatic peek(input logic [AW-1:0] a);
        rd_addr = a;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        int done_seen;
        logic [7:0] lines_or;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        lines_or = '0;
        for (int i = 0; i < 8; i++) begin
            peek(AW'(i));
            lines_or = lines_or | rd_data | {7'd0, rd_logged};
        end
        chk("R1 lines and flags", lines_or, 0);
        chk("R1 count", log_count, 0);
        chk("R1 busy", busy, 0);
        chk("R1 rb_done", rb_done, 0);
        chk("R1 wr_ready", wr_ready, 1);

        // Table walk: R2 R3 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][26:25])
                2'd0: do_write(VEC[i][24:22], VEC[i][21:14]);
                2'd1: pulse(1'b0);
                default: pulse(1'b1);
            endcase
            peek(VEC[i][13:11]);
            chk("R9 R2 R3 R5 R6 vector data", rd_data, VEC[i][10:3]);
            chk("R2 R5 R6 vector count", log_count, VEC[i][2:0]);
        end

        // R3 and R8: first-time write lands one cycle late; commit while busy ignored
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 3'd5; wr_data = 8'hA5;
        chk("R3 ready before miss", wr_ready, 1);
        @(negedge clk);
        wr_valid = 1'b0; ckpt_commit = 1'b1;
        peek(3'd5);
        chk("R3 old data held", rd_data, 8'h00);
        chk("R3 busy during data cycle", busy, 1);
        chk("R2 count after append", log_count, 1);
        @(negedge clk);
        ckpt_commit = 1'b0;
        peek(3'd5);
        chk("R3 new data landed", rd_data, 8'hA5);
        chk("R8 flag kept after busy commit", rd_logged, 1);
        chk("R8 count kept after busy commit", log_count, 1);

        // R4: fill, stall, hit while full
        do_write(3'd0, 8'h10);
        do_write(3'd1, 8'h20);
        do_write(3'd2, 8'h30);
        chk("R4 full count", log_count, 4);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 3'd6; wr_data = 8'h66;
        #1;
        chk("R4 miss stalled", wr_ready, 0);
        repeat (3) @(negedge clk);
        wr_valid = 1'b0;
        peek(3'd6);
        chk("R4 stalled line unchanged", rd_data, 8'h00);
        do_write(3'd0, 8'hB0);
        peek(3'd0);
        chk("R4 hit while full", rd_data, 8'hB0);

        // R5: first commit keeps recent entries, second frees them
        pulse(1'b0);
        peek(3'd0);
        chk("R5 flag cleared", rd_logged, 0);
        chk("R5 count after one commit", log_count, 4);
        pulse(1'b0);
        chk("R5 count after two commits", log_count, 0);
        do_write(3'd6, 8'hC6);
        do_write(3'd5, 8'hD5);
        do_write(3'd0, 8'hE0);
        chk("R5 count refilled", log_count, 3);

        // R6: rollback timing and restored image
        @(negedge clk);
        rollback_req = 1'b1;
        @(negedge clk);
        rollback_req = 1'b0;
        cyc = 0;
        for (int k = 0; k < 50 && busy; k++) begin
            cyc++;
            @(negedge clk);
        end
        chk("R6 busy cycles", cyc, 4);
        chk("R6 done pulse", rb_done, 1);
        @(negedge clk);
        done_seen = rb_done;
        chk("R6 done single cycle", done_seen, 0);
        peek(3'd0);
        chk("R6 line 0 restored", rd_data, 8'hB0);
        peek(3'd5);
        chk("R6 line 5 restored", rd_data, 8'hA5);
        chk("R6 flag cleared", rd_logged, 0);
        peek(3'd6);
        chk("R6 line 6 restored", rd_data, 8'h00);
        chk("R6 log empty", log_count, 0);

        // R7: pulse blocks a write in the same cycle
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 3'd3; wr_data = 8'h99; ckpt_commit = 1'b1;
        #1;
        chk("R7 ready low with commit", wr_ready, 0);
        ckpt_commit = 1'b0; rollback_req = 1'b1;
        #1;
        chk("R7 ready low with rollback", wr_ready, 0);
        ckpt_commit = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; ckpt_commit = 1'b0; rollback_req = 1'b0;
        chk("R7 rollback wins over commit", busy, 1);
        wait_idle();
        peek(3'd3);
        chk("R7 write not taken", rd_data, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule